// File: doc/BRIEF.md
# Iterative Multi-Cycle Shifter

This block is the shift unit of a small 32-bit RISC integer core. It is built to avoid the area of a single-cycle barrel network. A start strobe captures an operand, a 5-bit shift amount and a shift-type code. The unit then moves the operand one step per clock: four bit positions while at least four positions remain, and one position per clock for what is left. It supports logical left, logical right and arithmetic right shifts.

The core raises `startIn` for one cycle while the unit is idle. It then waits for `doneOut`, which is a single-cycle pulse, and reads `resultOut`. While a shift is in progress, `busyOut` is high and any further start strobes are dropped. The result register keeps its value until the next accepted start. The worst case, a 31-position shift, costs ten stepping cycles.

Top module: `iterShift`

## Requirements
- R1: After reset, `busyOut` and `doneOut` are 0 and `resultOut` is 0.
- R2: Kind code 2'b00 performs a logical left shift with zero fill. The reserved code 2'b11 behaves the same as 2'b00.
- R3: Kind code 2'b01 performs a logical right shift with zero fill.
- R4: Kind code 2'b10 performs an arithmetic right shift. Every vacated bit takes the value that bit 31 of the operand had at start.
- R5: Let edge 0 be the clock edge that samples an accepted start, and let S = floor(amount/4) + (amount mod 4). `doneOut` is high in exactly the cycle that follows edge S.
- R6: A shift amount of 0 returns the operand unchanged, with `doneOut` high in the cycle right after the start cycle.
- R7: `busyOut` is high from the cycle after an accepted start up to and including the done cycle, and low in the cycle after that.
- R8: `doneOut` lasts exactly one cycle for each accepted start.
- R9: A start raised while `busyOut` is high is ignored. The running shift keeps its operand, its amount and its latency.
- R10: Once done, `resultOut` holds its value until the next accepted start, whatever the other inputs do.
- R11: A 31-position shift takes 7 four-bit steps plus 3 one-bit steps, so `doneOut` follows edge 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startIn | input | 1 | Begin a shift (sampled only while idle) |
| operandIn | input | 32 | Value to shift |
| amountIn | input | 5 | Number of bit positions, 0 to 31 |
| kindIn | input | 2 | 00 logical left, 01 logical right, 10 arithmetic right, 11 as 00 |
| busyOut | output | 1 | Shift in progress, done cycle included |
| doneOut | output | 1 | One-cycle pulse when the result is final |
| resultOut | output | 32 | Shifted value, held after done |

## Verification
The checker watches the handshake on every cycle. It confirms that done only occurs while busy, that done is a single-cycle pulse, and that busy drops right after done. It also confirms that an accepted start raises busy, that a zero amount finishes at once, and that the result stays stable while idle. A cycle counter in the checker compares the done time against the step count derived from the captured amount. The actual shifted values cannot be checked this way, because they depend on the operand and the shift kind. Only the bench's vectors can show them, including sign fill, the reserved code, and a start that arrives in mid-shift.

// File: rtl/shiftPkg.sv
package shiftPkg;

  typedef enum logic [1:0] {
    SHK_LEFT  = 2'b00,
    SHK_RIGHT = 2'b01,
    SHK_ARITH = 2'b10,
    SHK_RSVD  = 2'b11
  } shiftKind_t;

  typedef struct packed {
    logic load;
    logic stepBig;
    logic stepOne;
  } shiftStrobes_t;

endpackage

// File: rtl/shiftCtrl.sv
module shiftCtrl
  import shiftPkg::*;
#(
  parameter int AMT_W   = 5,
  parameter int BIG_STEP = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic [AMT_W-1:0] amountIn,
  output shiftStrobes_t    strobes,
  output logic             busyOut,
  output logic             doneOut
);

  localparam logic [AMT_W-1:0] BIG_AMT = AMT_W'(BIG_STEP);
  localparam logic [AMT_W-1:0] ONE_AMT = AMT_W'(1);

  logic [AMT_W-1:0] remaining;
  logic             busyQ;
  logic             finalCycle;

  always_comb begin
    finalCycle      = busyQ && (remaining == '0);
    strobes.load    = startIn && !busyQ;
    strobes.stepBig = busyQ && (remaining >= BIG_AMT);
    strobes.stepOne = busyQ && (remaining != '0) && (remaining < BIG_AMT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ     <= 1'b0;
      remaining <= '0;
    end else if (strobes.load) begin
      busyQ     <= 1'b1;
      remaining <= amountIn;
    end else if (finalCycle) begin
      busyQ     <= 1'b0;
    end else if (strobes.stepBig) begin
      remaining <= remaining - BIG_AMT;
    end else if (strobes.stepOne) begin
      remaining <= remaining - ONE_AMT;
    end
  end

  assign busyOut = busyQ;
  assign doneOut = finalCycle;

endmodule

// File: rtl/shiftDatapath.sv
module shiftDatapath
  import shiftPkg::*;
#(
  parameter int WIDTH    = 32,
  parameter int BIG_STEP = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  shiftStrobes_t strobes,
  input  logic [WIDTH-1:0] operandIn,
  input  logic [1:0]    kindIn,
  output logic [WIDTH-1:0] resultOut
);

  localparam int NUM_STEPS = 2;

  logic [WIDTH-1:0] dataQ;
  shiftKind_t       kindQ;
  logic             goRight;
  logic             signFill;
  logic [WIDTH-1:0] stepped [NUM_STEPS];

  always_comb begin
    goRight  = (kindQ == SHK_RIGHT) || (kindQ == SHK_ARITH);
    signFill = (kindQ == SHK_ARITH) && dataQ[WIDTH-1];
  end

  // index 0: wide step, index 1: single-bit step
  for (genvar g = 0; g < NUM_STEPS; g++) begin : gStep
    localparam int AMT = (g == 0) ? BIG_STEP : 1;
    logic [WIDTH-1:0] leftVal;
    logic [WIDTH-1:0] rightVal;
    always_comb begin
      leftVal  = {dataQ[WIDTH-1-AMT:0], {AMT{1'b0}}};
      rightVal = {{AMT{signFill}}, dataQ[WIDTH-1:AMT]};
    end
    assign stepped[g] = goRight ? rightVal : leftVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ <= '0;
      kindQ <= SHK_LEFT;
    end else if (strobes.load) begin
      dataQ <= operandIn;
      kindQ <= shiftKind_t'(kindIn);
    end else if (strobes.stepBig) begin
      dataQ <= stepped[0];
    end else if (strobes.stepOne) begin
      dataQ <= stepped[1];
    end
  end

  assign resultOut = dataQ;

endmodule

// File: rtl/iterShift.sv
module iterShift
  import shiftPkg::*;
#(
  parameter int WIDTH    = 32,
  parameter int BIG_STEP = 4,
  parameter int AMT_W    = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic [WIDTH-1:0] operandIn,
  input  logic [AMT_W-1:0] amountIn,
  input  logic [1:0]       kindIn,
  output logic             busyOut,
  output logic             doneOut,
  output logic [WIDTH-1:0] resultOut
);

  shiftStrobes_t strobes;

  shiftCtrl #(.AMT_W(AMT_W), .BIG_STEP(BIG_STEP)) uCtrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .amountIn(amountIn),
    .strobes(strobes), .busyOut(busyOut), .doneOut(doneOut)
  );

  shiftDatapath #(.WIDTH(WIDTH), .BIG_STEP(BIG_STEP)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .operandIn(operandIn),
    .kindIn(kindIn), .resultOut(resultOut)
  );

endmodule

// File: rtl/iterShiftChecker.sv
module iterShiftChecker #(
  parameter int WIDTH    = 32,
  parameter int BIG_STEP = 4,
  parameter int AMT_W    = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             startIn,
  input logic [AMT_W-1:0] amountIn,
  input logic             busyOut,
  input logic             doneOut,
  input logic [WIDTH-1:0] resultOut
);

  logic [7:0] latCnt;
  logic [7:0] latExp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latCnt <= '0;
      latExp <= '0;
    end else if (startIn && !busyOut) begin
      latCnt <= '0;
      latExp <= 8'(int'(amountIn) / BIG_STEP + int'(amountIn) % BIG_STEP);
    end else if (busyOut) begin
      latCnt <= latCnt + 8'd1;
    end
  end

  AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> busyOut); // R7
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !busyOut); // R7
  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (startIn && !busyOut) |=> busyOut); // R7
  AST_SINGLE_DONE: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut); // R8
  AST_ZERO_FAST: assert property (@(posedge clk) disable iff (!rstN)
    (startIn && !busyOut && amountIn == '0) |=> doneOut); // R6
  AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (busyOut && !doneOut) |=> busyOut); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!busyOut && !startIn) |=> $stable(resultOut)); // R10
  AST_STEP_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> (latCnt == latExp)); // R5

endmodule

bind iterShift iterShiftChecker #(.WIDTH(WIDTH), .BIG_STEP(BIG_STEP), .AMT_W(AMT_W)) uChk (
  .clk(clk), .rstN(rstN), .startIn(startIn), .amountIn(amountIn),
  .busyOut(busyOut), .doneOut(doneOut), .resultOut(resultOut)
);

// File: tb/sim_iterShift.sv
`timescale 1ns/1ps
module sim_iterShift;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startIn = 1'b0;
  logic [31:0] operandIn = '0;
  logic [4:0]  amountIn = '0;
  logic [1:0]  kindIn = '0;
  logic        busyOut;
  logic        doneOut;
  logic [31:0] resultOut;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  iterShift u0 (
    .clk(clk), .rstN(rstN), .startIn(startIn), .operandIn(operandIn),
    .amountIn(amountIn), .kindIn(kindIn), .busyOut(busyOut),
    .doneOut(doneOut), .resultOut(resultOut)
  );

  // {kind, amount, operand}
  localparam logic [38:0] VECS [12] = '{
    {2'b00, 5'd5,  32'h0000_0001},
    {2'b00, 5'd31, 32'h0000_0003},
    {2'b01, 5'd4,  32'hF000_0000},
    {2'b01, 5'd31, 32'h8000_0000},
    {2'b10, 5'd7,  32'h8000_0F00},
    {2'b10, 5'd31, 32'h8000_0000},
    {2'b10, 5'd3,  32'h7FFF_FFFF},
    {2'b00, 5'd0,  32'hDEAD_BEEF},
    {2'b01, 5'd1,  32'hA5A5_A5A5},
    {2'b10, 5'd12, 32'hC000_1234},
    {2'b11, 5'd8,  32'h0000_00FF},
    {2'b01, 5'd16, 32'h1234_5678}
  };

  function automatic logic [31:0] refShift(logic [31:0] op, logic [4:0] amt, logic [1:0] kind);
    case (kind)
      2'b01:   return op >> amt;
      2'b10:   return 32'($signed(op) >>> amt);
      default: return op << amt;
    endcase
  endfunction

  function automatic int refLat(logic [4:0] amt);
    return int'(amt) / 4 + int'(amt) % 4;
  endfunction

  function automatic string kindTag(logic [1:0] kind);
    case (kind)
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Starts a shift, waits for done; returns edges from sampling edge to done.
  task automatic runShift(input logic [31:0] op, input logic [4:0] amt, input logic [1:0] kind,
                          output int lat, output bit busyOk);
    @(negedge clk);
    startIn = 1'b1; operandIn = op; amountIn = amt; kindIn = kind;
    @(posedge clk);
    @(negedge clk);
    startIn = 1'b0;
    lat = 0;
    busyOk = busyOut;
    while (!doneOut && lat < 100) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
      if (!busyOut) busyOk = 1'b0;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    bit busyOk;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busyOut && !doneOut, "R1 flags", {30'd0, busyOut, doneOut}, 32'd0);
    check(resultOut == 32'd0, "R1 result", resultOut, 32'd0);
    rstN = 1'b1;

    // vector table: R2 R3 R4 R5 R6 R11
    for (int i = 0; i < 12; i++) begin
      logic [1:0]  k;
      logic [4:0]  a;
      logic [31:0] o;
      {k, a, o} = VECS[i];
      runShift(o, a, k, lat, busyOk);
      check(resultOut == refShift(o, a, k), kindTag(k), resultOut, refShift(o, a, k));
      check(lat == refLat(a), (a == 5'd31) ? "R11 latency" : "R5 latency", 32'(lat), 32'(refLat(a)));
      check(busyOk, "R7 busy during shift", {31'd0, busyOk}, 32'd1);
      if (a == 5'd0) check(resultOut == o, "R6 zero amount", resultOut, o);
      @(negedge clk);
      check(!busyOut && !doneOut, "R7 R8 idle after done", {30'd0, busyOut, doneOut}, 32'd0);
    end

    // R10 hold after done while inputs wiggle
    runShift(32'h0F0F_0000, 5'd6, 2'b01, lat, busyOk);
    held = resultOut;
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      operandIn = 32'hFFFF_FFFF - 32'(j);
      amountIn = 5'(j);
      kindIn = 2'(j);
    end
    check(resultOut == held && held == 32'h003C_3C00, "R10 hold", resultOut, 32'h003C_3C00);

    // R9 start while busy ignored
    @(negedge clk);
    startIn = 1'b1; operandIn = 32'h8765_4321; amountIn = 5'd20; kindIn = 2'b01;
    @(posedge clk);
    @(negedge clk);
    startIn = 1'b0;
    lat = 0;
    @(posedge clk); @(negedge clk); lat++;
    startIn = 1'b1; operandIn = 32'h1111_1111; amountIn = 5'd0; kindIn = 2'b00;
    @(posedge clk); @(negedge clk); lat++;
    startIn = 1'b0;
    while (!doneOut && lat < 100) begin
      @(posedge clk); @(negedge clk); lat++;
    end
    check(lat == 5, "R9 latency kept", 32'(lat), 32'd5);
    check(resultOut == 32'h0000_0876, "R9 operand kept", resultOut, 32'h0000_0876);
    @(negedge clk);
    check(!doneOut, "R8 no second done", {31'd0, doneOut}, 32'd0);

    // R4 sign fill from original bit 31 with mixed steps
    runShift(32'hF000_0001, 5'd9, 2'b10, lat, busyOk);
    check(resultOut == 32'hFFF8_0000, "R4 sign fill", resultOut, 32'hFFF8_0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule